// File: doc/BRIEF.md
# Serial Control-Register Slave for an Audio Decoder

This block is a two-wire bus (I2C) slave that lets a host set up a broadcast audio decoder. The host writes a sub-address byte and then one or more data bytes into a bank of three 8-bit control registers. The block decodes the register contents onto parallel outputs: the mono-channel selection bits, a three-bit switching code, a direct output pin bit, mute controls and two error-count thresholds. A read transaction returns one status byte that comes from the decoder core.

The bus lines are sampled by the system clock through a two-stage synchroniser. START and STOP are detected from SDA edges that occur while SCL is high. The 7-bit address is fixed except for its least significant bit, which is taken from a strap input. Each written byte is stored at the current sub-address, and the pointer then advances, wrapping from the last register back to the first. A START or a STOP at any point aborts the byte in progress.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: After reset the registers hold 0x90 (index 0), 0x50 (index 1) and 0x14 (index 2). Register 0 maps bit 7 to `dual_pick`, bit 6 to `dual_both`, bits 5..3 to `sw_sel[2:0]`, bit 2 to `port_pin`, bit 1 to `mute_dflt` and bit 0 to `amute_off`. The reset outputs are therefore dual_pick=1, dual_both=0, sw_sel=3'b010, port_pin=0, mute_dflt=0 and amute_off=0.
- R2: An address byte whose upper seven bits equal 1,0,1,1,0,1,`addr_sel` is acknowledged; bit 0 of that byte is R/W, with 0 meaning write. Any other address is not acknowledged, and the bytes that follow it change no register.
- R3: The general-call address byte 0x00 is never acknowledged.
- R4: In a write, the first byte after the address is the sub-address and each following byte is stored at the current sub-address. Index 1 drives `err_hi` and index 2 drives `err_lo`. Every byte is acknowledged by pulling SDA low for the ninth clock.
- R5: After each stored data byte the sub-address increments, and it wraps from 2 back to 0.
- R6: A sub-address of 3 or more is not acknowledged, and the data bytes that follow it are neither acknowledged nor stored until the next START.
- R7: A STOP or a repeated START in the middle of a byte aborts that byte without storing it and returns the slave to address matching.
- R8: A read (R/W=1) returns `status_i` MSB first. The value is captured when the address acknowledge ends and again after each master ACK. After a master NACK the slave releases SDA.
- R9: `port_pin` follows bit 2 of register 0 as soon as that register is written.
- R10: The registers change only when an acknowledged data byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High to pull SDA low (open-drain drive) |
| addr_sel | input | 1 | Strap that sets address bit 0 |
| status_i | input | 8 | Status byte returned on reads |
| dual_pick | output | 1 | Register 0 bit 7, mono channel pick |
| dual_both | output | 1 | Register 0 bit 6, one or both mono channels |
| sw_sel | output | 3 | Register 0 bits 5..3, source switching code |
| port_pin | output | 1 | Register 0 bit 2, general output pin |
| mute_dflt | output | 1 | Register 0 bit 1, default mute state |
| amute_off | output | 1 | Register 0 bit 0, disables automatic mute |
| err_hi | output | 8 | Register 1, upper error-count limit |
| err_lo | output | 8 | Register 2, lower error-count limit |

## Verification
The bound checker watches the sub-address pointer on every clock. It checks that the pointer stays in range, that it steps by one and wraps from 2 to 0 after each stored byte, and that the registers hold whenever no write strobe fires. The checker also covers three cases on every cycle: SDA is released after a STOP, a general-call address leaves SDA released, and no write happens while the slave waits for a START. Only the bench's bus scenarios can show the acknowledge pattern seen on the wire, the field mapping of stored bytes, MSB-first read data with a status byte captured per byte, and the abort of a partly shifted byte.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int NREG = 3;
  localparam int DW   = 8;
  localparam int PW   = $clog2(NREG);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_SUB, S_WDATA, S_RDATA, S_RACK
  } i2c_st_t;

  // power-on contents of each control register
  function automatic logic [DW-1:0] rst_val(input int idx);
    case (idx)
      0:       rst_val = 8'h90;
      1:       rst_val = 8'h50;
      default: rst_val = 8'h14;
    endcase
  endfunction

  // pointer step with wrap after the last register
  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    next_ptr = (int'(p) == NREG - 1) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/ctlreg_line_sync.sv
module ctlreg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_sh[STAGES-1];
  assign scl_p = scl_sh[STAGES];
  assign sda_s = sda_sh[STAGES-1];
  assign sda_p = sda_sh[STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ctlreg_proto_fsm.sv
module ctlreg_proto_fsm
  import ctlreg_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b101101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          addr_sel,
  input  logic [DW-1:0] status_i,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          addr_eval,
  output logic [DW-1:0] rx_byte,
  output logic          idle
);
  i2c_st_t       state, nxt;
  logic [3:0]    cnt;
  logic [DW-1:0] sh, tx;
  logic [PW-1:0] ptr;
  logic          mack;
  logic          rx_state, byte_done, addr_hit, sub_ok;

  assign rx_state  = (state == S_ADDR) || (state == S_SUB) || (state == S_WDATA);
  assign byte_done = rx_state && scl_fall && (cnt == 4'd8);
  assign addr_hit  = (sh[7:1] == {ADDR_HI, addr_sel});
  assign sub_ok    = (int'(sh) < NREG);
  assign addr_eval = (state == S_ADDR) && byte_done;
  assign wr_en     = (state == S_WDATA) && byte_done;
  assign wr_idx    = ptr;
  assign wr_data   = sh;
  assign rx_byte   = sh;
  assign idle      = (state == S_IDLE);
  assign sda_oe    = (state == S_ACK) || ((state == S_RDATA) && !tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      nxt   <= S_IDLE;
      cnt   <= '0;
      sh    <= '0;
      tx    <= '0;
      ptr   <= '0;
      mack  <= 1'b0;
    end else if (start_det) begin
      state <= S_ADDR;
      cnt   <= '0;
    end else if (stop_det) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_ADDR, S_SUB, S_WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[DW-2:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          if (byte_done) begin
            cnt <= '0;
            if (state == S_ADDR) begin
              if (addr_hit) begin
                state <= S_ACK;
                nxt   <= sh[0] ? S_RDATA : S_SUB;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_SUB) begin
              if (sub_ok) begin
                ptr   <= sh[PW-1:0];
                state <= S_ACK;
                nxt   <= S_WDATA;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              ptr   <= next_ptr(ptr);
              state <= S_ACK;
              nxt   <= S_WDATA;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          state <= nxt;
          cnt   <= '0;
          tx    <= status_i;
        end
        S_RDATA: if (scl_fall) begin
          if (cnt == 4'd7) begin
            state <= S_RACK;
            cnt   <= '0;
          end else begin
            tx  <= {tx[DW-2:0], 1'b0};
            cnt <= cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              state <= S_RDATA;
              tx    <= status_i;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_flat[g*DW +: DW] <= rst_val(g);
      else if (wr_en && (wr_idx == PW'(g)))
        regs_flat[g*DW +: DW] <= wr_data;
    end
  end
endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave
  import ctlreg_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b101101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          addr_sel,
  input  logic [DW-1:0] status_i,
  output logic          dual_pick,
  output logic          dual_both,
  output logic [2:0]    sw_sel,
  output logic          port_pin,
  output logic          mute_dflt,
  output logic          amute_off,
  output logic [DW-1:0] err_hi,
  output logic [DW-1:0] err_lo
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, addr_eval, idle;
  logic [PW-1:0] wr_idx;
  logic [DW-1:0] wr_data, rx_byte;
  logic [NREG*DW-1:0] regs_flat;

  ctlreg_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ctlreg_proto_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .status_i(status_i), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .addr_eval(addr_eval), .rx_byte(rx_byte), .idle(idle)
  );

  ctlreg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  assign dual_pick = regs_flat[7];
  assign dual_both = regs_flat[6];
  assign sw_sel    = regs_flat[5:3];
  assign port_pin  = regs_flat[2];
  assign mute_dflt = regs_flat[1];
  assign amute_off = regs_flat[0];
  assign err_hi    = regs_flat[DW +: DW];
  assign err_lo    = regs_flat[2*DW +: DW];
endmodule

// File: rtl/ctlreg_i2c_checks.sv
module ctlreg_i2c_checks
  import ctlreg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               stop_det,
  input logic               wr_en,
  input logic [PW-1:0]      wr_idx,
  input logic               addr_eval,
  input logic [DW-1:0]      rx_byte,
  input logic               idle,
  input logic               sda_oe,
  input logic [NREG*DW-1:0] regs_flat
);
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_idx) < NREG);                                              // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) == NREG - 1) |=> (wr_idx == '0));           // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) != NREG - 1) |=> (wr_idx == $past(wr_idx) + 1'b1)); // R5
  AST_NO_GCALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_eval && rx_byte == '0) |=> !sda_oe);                         // R3
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);                                             // R7
  AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !wr_en);                                                  // R6
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));                                    // R10
endmodule

bind ctlreg_i2c_slave ctlreg_i2c_checks u_chk (
  .clk(clk), .rst_n(rst_n), .stop_det(stop_det), .wr_en(wr_en),
  .wr_idx(wr_idx), .addr_eval(addr_eval), .rx_byte(rx_byte),
  .idle(idle), .sda_oe(sda_oe), .regs_flat(regs_flat)
);

// File: tb/ctlreg_i2c_slave_bench.sv
`timescale 1ns/1ps
module ctlreg_i2c_slave_bench;
  localparam int Q = 10;  // clocks per quarter bit
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic [7:0] status_i = 8'h00;
  logic sda_oe, dual_pick, dual_both, port_pin, mute_dflt, amute_off;
  logic [2:0] sw_sel;
  logic [7:0] err_hi, err_lo;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_r [3];

  always #2.5 clk = ~clk;

  ctlreg_i2c_slave u_ctlreg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .status_i(status_i), .dual_pick(dual_pick),
    .dual_both(dual_both), .sw_sel(sw_sel), .port_pin(port_pin),
    .mute_dflt(mute_dflt), .amute_off(amute_off), .err_hi(err_hi), .err_lo(err_lo)
  );

  // stimulus vectors: {sub-address, data, expected sub-address ack}
  localparam logic [16:0] VEC [6] = '{
    {8'h00, 8'h5A, 1'b1}, {8'h01, 8'hC3, 1'b1}, {8'h02, 8'h07, 1'b1},
    {8'h03, 8'hFF, 1'b0}, {8'h80, 8'h11, 1'b0}, {8'h00, 8'hE4, 1'b1}
  };

  function automatic logic [7:0] reg_at(input int i);
    case (i)
      0:       reg_at = {dual_pick, dual_both, sw_sel, port_pin, mute_dflt, amute_off};
      1:       reg_at = err_hi;
      default: reg_at = err_lo;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 3; i++) check(req, reg_at(i), exp_r[i]);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = ~mack; scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic write1(input logic [7:0] sub, input logic [7:0] d,
                        output logic aa, output logic sa, output logic da);
    i2c_start; send_byte(addr_sel ? 8'hB6 : 8'hB4, aa);
    send_byte(sub, sa); send_byte(d, da); i2c_stop;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic aa, sa, da;
    logic [7:0] rb;
    exp_r[0] = 8'h90; exp_r[1] = 8'h50; exp_r[2] = 8'h14;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset values and field mapping
    check_regs("R1 reset");
    check("R1 sw_sel reset", {5'd0, sw_sel}, 8'h02);
    check("R9 port_pin reset", {7'd0, port_pin}, 8'h00);
    check("R1 sda released", {7'd0, sda_oe}, 8'h00);

    // table walk: R4 stores, R6 bad sub-addresses
    for (int v = 0; v < 6; v++) begin
      write1(VEC[v][16:9], VEC[v][8:1], aa, sa, da);
      check("R2 addr ack", {7'd0, aa}, 8'h01);
      check("R4/R6 sub ack", {7'd0, sa}, {7'd0, VEC[v][0]});
      check("R4/R6 data ack", {7'd0, da}, {7'd0, VEC[v][0]});
      if (VEC[v][0]) exp_r[VEC[v][10:9]] = VEC[v][8:1];
      check_regs("R4 table store");
    end

    // R5 burst of four bytes starting at index 1 wraps 2 -> 0
    i2c_start; send_byte(8'hB4, aa); send_byte(8'h01, sa);
    send_byte(8'hA1, da); send_byte(8'hA2, da); send_byte(8'hA3, da);
    send_byte(8'hA4, da); i2c_stop;
    check("R5 ack in burst", {7'd0, da}, 8'h01);
    exp_r[1] = 8'hA4; exp_r[2] = 8'hA2; exp_r[0] = 8'hA3;
    check_regs("R5 wrap");

    // R9 port pin follows bit 2 of register 0
    write1(8'h00, 8'h04, aa, sa, da); exp_r[0] = 8'h04;
    check("R9 port_pin set", {7'd0, port_pin}, 8'h01);
    write1(8'h00, 8'hFB, aa, sa, da); exp_r[0] = 8'hFB;
    check("R9 port_pin clear", {7'd0, port_pin}, 8'h00);

    // R2 strap-selected address bit
    addr_sel = 1'b1;
    write1(8'h01, 8'h66, aa, sa, da);
    check("R2 strap addr ack", {7'd0, aa}, 8'h01); exp_r[1] = 8'h66;
    i2c_start; send_byte(8'hB4, aa); send_byte(8'h01, sa); send_byte(8'h99, da); i2c_stop;
    check("R2 wrong addr nack", {7'd0, aa}, 8'h00);
    check("R10 no ack after miss", {7'd0, da}, 8'h00);
    check_regs("R10 no store after miss");
    addr_sel = 1'b0;

    // R3 general call
    i2c_start; send_byte(8'h00, aa); send_byte(8'h00, sa); send_byte(8'h55, da); i2c_stop;
    check("R3 general call nack", {7'd0, aa}, 8'h00);
    check_regs("R3 no store");

    // R7 abort by STOP mid-byte, then by repeated START
    i2c_start; send_byte(8'hB4, aa); send_byte(8'h00, sa); send_bits(8'h0F, 5); i2c_stop;
    check_regs("R7 stop abort");
    i2c_start; send_byte(8'hB4, aa); send_byte(8'h01, sa); send_bits(8'h00, 3);
    i2c_start; send_byte(8'hB4, aa); send_byte(8'h02, sa); send_byte(8'h33, da); i2c_stop;
    check("R7 restart addr ack", {7'd0, aa}, 8'h01);
    exp_r[2] = 8'h33;
    check_regs("R7 restart abort");

    // R8 read with ACK then NACK
    status_i = 8'hA5;
    i2c_start; send_byte(8'hB5, aa);
    check("R8 read addr ack", {7'd0, aa}, 8'h01);
    status_i = 8'h3C;
    recv_byte(1'b1, rb);
    check("R8 first read byte", rb, 8'hA5);
    recv_byte(1'b0, rb);
    check("R8 second read byte", rb, 8'h3C);
    tick(Q);
    check("R8 release after nack", {7'd0, sda_oe}, 8'h00);
    i2c_stop;
    check_regs("R10 read leaves regs");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule